// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is a single capture lane of a general-purpose timer. It takes the channel's own pin, the already filtered level of the adjacent channel, and a one-cycle trigger pulse from the timer's slave controller. It also receives the free-running timer count and a set of static configuration fields. The own pin is first brought into the clock domain by a two-stage synchronizer. A programmable glitch filter then cleans it, and the filter advances only on cycles where the sample strobe is high. Rising and falling transitions of the cleaned level are detected, and a polarity setting picks which transitions count.

A source selector chooses what commands a capture: the own pin's active edge, the adjacent level's active edge, or the trigger pulse. A prescaler passes only one of every 1, 2, 4 or 8 commands. Each passed command copies the timer count into the capture register and raises a capture flag. A command that arrives while that flag is still set also raises an overrun flag. The cleaned level, its raw edge pulses and its polarity-selected edge pulse are all exported, so the slave controller can use them as trigger sources.

Top module: `captureChannel`

## Requirements
- R1: While `rstN` is low, `capVal`, `capFlag`, `ovrFlag` and `filtOut` are all 0.
- R2: With `fltSel` = 0, `filtOut` equals `ownIn` as it was three clock edges earlier (two synchronizer stages plus the filter register).
- R3: With `fltSel` = k > 0, `filtOut` changes only after 2·k consecutive `sampleTick` cycles on which the synchronized input differs from `filtOut`. A shorter run has no effect. Cycles with `sampleTick` low take no sample.
- R4: `riseEvt` (and `fallEvt`) is high for exactly one cycle after each 0→1 (1→0) change of `filtOut`. The two are never high together.
- R5: `polSel` encoding: 00 makes rising edges active, 01 makes falling edges active, and 1x makes both active. `ownTrig` pulses for one cycle on each active edge of `filtOut`.
- R6: `srcSel` encoding: 01 means the own active edge, 10 means the active edge of `nbrFilt` (same polarity rule), and 11 means `trigIn`. With 00, nothing is captured. A source that is not selected never causes a capture.
- R7: `divSel` = d makes one capture for every 2^d selected commands. With n commands after a prescaler reset, the number of captures is n >> d.
- R8: A capture loads `cntVal` into `capVal` on the clock edge where the command is seen, and sets `capFlag`. While `capEn` is 0, no capture occurs.
- R9: A capture while `capFlag` is set sets `ovrFlag`. `flagClr` clears both flags. A capture in the same cycle as `flagClr` leaves `capFlag` = 1 and `ovrFlag` = 0.
- R10: The prescaler's event count restarts from zero whenever `capEn` is low, `srcSel` is 00, or `divSel` differs from its value in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleTick | input | 1 | Filter sample strobe |
| ownIn | input | 1 | Own external pin (asynchronous) |
| nbrFilt | input | 1 | Filtered level of the adjacent channel |
| trigIn | input | 1 | One-cycle trigger pulse from the slave controller |
| cntVal | input | CW | Timer count value |
| fltSel | input | FW | Filter length setting |
| polSel | input | 2 | Active edge selection |
| srcSel | input | 2 | Capture source selection |
| divSel | input | DW | Prescaler ratio exponent |
| capEn | input | 1 | Capture enable |
| flagClr | input | 1 | Clears the capture and overrun flags |
| filtOut | output | 1 | Filtered own input level |
| riseEvt | output | 1 | Rising edge pulse of filtOut |
| fallEvt | output | 1 | Falling edge pulse of filtOut |
| ownTrig | output | 1 | Polarity-selected edge pulse of filtOut |
| capVal | output | CW | Capture register |
| capFlag | output | 1 | Capture occurred |
| ovrFlag | output | 1 | Capture occurred while capFlag was set |

## Verification
A corrupted filter counter shows up at `filtOut`. The output switches before or after the 2·k-sample boundary, or a short glitch gets through, and either is visible within a few cycles of the stimulus. A wrong prescaler count changes which command yields a capture, so `capVal` holds the count from a different trigger and the flags disagree with n >> d as soon as the burst ends. Flag state errors appear at `capFlag` and `ovrFlag` on the edge right after the offending capture or clear.

// File: rtl/capPkg.sv
package capPkg;
  // Strobes from the control section to the capture datapath
  typedef struct packed {
    logic capture;
    logic clear;
  } capStrobe_t;

  // Consecutive differing samples required for filter setting sel
  function automatic int unsigned needSamples(input int unsigned sel);
    return 2 * sel;
  endfunction
endpackage

// File: rtl/capFilter.sv
module capFilter #(
  parameter int FW   = 4,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sampleTick,
  input  logic          rawIn,
  input  logic [FW-1:0] fltSel,
  output logic          filtOut
);
  localparam int MAXN = 2 * ((1 << FW) - 1);
  localparam int CNTW = $clog2(MAXN + 1);

  logic [SYNC-1:0] syncQ;
  logic            syncd;
  logic [CNTW-1:0] runCnt;
  logic [CNTW-1:0] need;

  generate
    if (SYNC == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= rawIn;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC-2:0], rawIn};
    end
  endgenerate

  assign syncd = syncQ[SYNC-1];

  always_comb need = CNTW'(capPkg::needSamples(32'(fltSel)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtOut <= 1'b0;
      runCnt  <= '0;
    end else if (fltSel == '0) begin
      filtOut <= syncd;
      runCnt  <= '0;
    end else if (sampleTick) begin
      if (syncd == filtOut) begin
        runCnt <= '0;
      end else if (runCnt == need - CNTW'(1)) begin
        filtOut <= syncd;
        runCnt  <= '0;
      end else begin
        runCnt <= runCnt + CNTW'(1);
      end
    end
  end
endmodule

// File: rtl/capCtrl.sv
module capCtrl #(
  parameter int DW = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ownFilt,
  input  logic                nbrFilt,
  input  logic                trigIn,
  input  logic [1:0]          polSel,
  input  logic [1:0]          srcSel,
  input  logic [DW-1:0]       divSel,
  input  logic                capEn,
  input  logic                flagClr,
  output logic                riseEvt,
  output logic                fallEvt,
  output logic                ownTrig,
  output capPkg::capStrobe_t  strobe
);
  localparam int PW = (1 << DW) - 1;

  logic [1:0] lvl, prevLvl, rise, fall, active;
  logic       cmd, prescReset, fire;
  logic [PW-1:0] divCnt, divLast;
  logic [DW-1:0] divPrev;

  assign lvl = {nbrFilt, ownFilt};

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) prevLvl <= '0;
    else       prevLvl <= lvl;

  for (genvar i = 0; i < 2; i++) begin : g_edge
    assign rise[i]   = lvl[i] & ~prevLvl[i];
    assign fall[i]   = ~lvl[i] & prevLvl[i];
    assign active[i] = polSel[1] ? (rise[i] | fall[i])
                                 : (polSel[0] ? fall[i] : rise[i]);
  end

  assign riseEvt = rise[0];
  assign fallEvt = fall[0];
  assign ownTrig = active[0];

  always_comb begin
    case (srcSel)
      2'b01:   cmd = active[0];
      2'b10:   cmd = active[1];
      2'b11:   cmd = trigIn;
      default: cmd = 1'b0;
    endcase
  end

  always_comb
    for (int b = 0; b < PW; b++) divLast[b] = (b < int'(divSel));

  assign prescReset = !capEn || (srcSel == 2'b00) || (divSel != divPrev);
  assign fire       = cmd && !prescReset && (divCnt == divLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      divPrev <= '0;
    end else begin
      divPrev <= divSel;
      if (prescReset)  divCnt <= '0;
      else if (cmd)    divCnt <= (divCnt == divLast) ? '0 : divCnt + PW'(1);
    end
  end

  assign strobe.capture = fire;
  assign strobe.clear   = flagClr;
endmodule

// File: rtl/capData.sv
module capData #(
  parameter int CW = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  capPkg::capStrobe_t strobe,
  input  logic [CW-1:0]      cntVal,
  output logic [CW-1:0]      capVal,
  output logic               capFlag,
  output logic               ovrFlag
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capVal  <= '0;
      capFlag <= 1'b0;
      ovrFlag <= 1'b0;
    end else if (strobe.capture) begin
      capVal  <= cntVal;
      capFlag <= 1'b1;
      ovrFlag <= strobe.clear ? 1'b0 : (ovrFlag | capFlag);
    end else if (strobe.clear) begin
      capFlag <= 1'b0;
      ovrFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/captureChannel.sv
module captureChannel #(
  parameter int CW   = 16,
  parameter int FW   = 4,
  parameter int DW   = 2,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sampleTick,
  input  logic          ownIn,
  input  logic          nbrFilt,
  input  logic          trigIn,
  input  logic [CW-1:0] cntVal,
  input  logic [FW-1:0] fltSel,
  input  logic [1:0]    polSel,
  input  logic [1:0]    srcSel,
  input  logic [DW-1:0] divSel,
  input  logic          capEn,
  input  logic          flagClr,
  output logic          filtOut,
  output logic          riseEvt,
  output logic          fallEvt,
  output logic          ownTrig,
  output logic [CW-1:0] capVal,
  output logic          capFlag,
  output logic          ovrFlag
);
  capPkg::capStrobe_t strobe;

  capFilter #(.FW(FW), .SYNC(SYNC)) uFilter (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rawIn(ownIn),
    .fltSel(fltSel), .filtOut(filtOut)
  );

  capCtrl #(.DW(DW)) uCtrl (
    .clk(clk), .rstN(rstN), .ownFilt(filtOut), .nbrFilt(nbrFilt),
    .trigIn(trigIn), .polSel(polSel), .srcSel(srcSel), .divSel(divSel),
    .capEn(capEn), .flagClr(flagClr), .riseEvt(riseEvt), .fallEvt(fallEvt),
    .ownTrig(ownTrig), .strobe(strobe)
  );

  capData #(.CW(CW)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cntVal(cntVal),
    .capVal(capVal), .capFlag(capFlag), .ovrFlag(ovrFlag)
  );
endmodule

// File: rtl/captureChannelChk.sv
module captureChannelChk #(
  parameter int CW = 16,
  parameter int FW = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          ownIn,
  input logic [CW-1:0] cntVal,
  input logic [FW-1:0] fltSel,
  input logic [1:0]    polSel,
  input logic [1:0]    srcSel,
  input logic          capEn,
  input logic          filtOut,
  input logic          riseEvt,
  input logic          fallEvt,
  input logic          ownTrig,
  input logic [CW-1:0] capVal,
  input logic          capFlag,
  input logic          ovrFlag
);
  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)              sinceRst <= '0;
    else if (sinceRst != 3) sinceRst <= sinceRst + 2'd1;

  // R1: everything cleared while reset is held
  always @(negedge clk)
    if (!rstN) a_r1_reset_clear: assert (capVal == '0 && !capFlag && !ovrFlag && !filtOut);

  // R2: pass-through filter is a three-edge delay of the pin
  a_r2_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 3 && fltSel == '0 && $past(fltSel) == '0 && $past(fltSel, 2) == '0)
      |-> filtOut == $past(ownIn, 3));

  // R4: rise and fall pulses never coincide
  a_r4_edge_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(riseEvt && fallEvt));

  // R5: rising-only mode never exports a falling edge, and vice versa
  a_r5_rise_only: assert property (@(posedge clk) disable iff (!rstN)
    (polSel == 2'b00) |-> !(ownTrig && fallEvt));
  a_r5_fall_only: assert property (@(posedge clk) disable iff (!rstN)
    (polSel == 2'b01) |-> !(ownTrig && riseEvt));

  // R6: output mode never captures
  a_r6_off_no_capture: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == 2'b00) |=> ($stable(capVal) && !$rose(capFlag)));

  // R8: capture takes the count seen at the capturing edge
  a_r8_cap_value: assert property (@(posedge clk) disable iff (!rstN)
    $rose(capFlag) |-> capVal == $past(cntVal));

  // R8: disabled channel holds its capture register
  a_r8_hold_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !capEn |=> $stable(capVal));

  // R9: overrun only follows a pending capture
  a_r9_ovr_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrFlag) |-> $past(capFlag));
endmodule

bind captureChannel captureChannelChk #(.CW(CW), .FW(FW)) chk (.*);

// File: tb/captureChannel_test.sv
module captureChannel_test;
  localparam int CW = 16;

  logic clk = 1'b0, rstN = 1'b1, sampleTick = 1'b1, ownIn = 1'b0, nbrFilt = 1'b0;
  logic trigIn = 1'b0, capEn = 1'b0, flagClr = 1'b0;
  logic [CW-1:0] cntVal = '0;
  logic [3:0] fltSel = '0;
  logic [1:0] polSel = '0, srcSel = '0, divSel = '0;
  logic filtOut, riseEvt, fallEvt, ownTrig, capFlag, ovrFlag;
  logic [CW-1:0] capVal;

  int nChecks = 0, nFail = 0;
  int nRise = 0, nFall = 0, nTrig = 0;

  captureChannel uut (.*);

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (riseEvt) nRise++;
    if (fallEvt) nFall++;
    if (ownTrig) nTrig++;
  end

  task automatic checkEq(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseTrig(logic [CW-1:0] v);
    trigIn = 1'b1; cntVal = v;
    @(negedge clk);
    trigIn = 1'b0;
  endtask

  task automatic clearFlags();
    flagClr = 1'b1; tick(1); flagClr = 1'b0;
  endtask

  task automatic restartPresc();
    capEn = 1'b0; tick(1); capEn = 1'b1;
  endtask

  task automatic zeroCounts();
    nRise = 0; nFall = 0; nTrig = 0;
  endtask

  function automatic int expCaps(int n, int d);
    return n >> d;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #1 rstN = 1'b0;
    tick(3);
    checkEq("R1 capVal", int'(capVal), 0);
    checkEq("R1 capFlag", int'(capFlag), 0);
    checkEq("R1 ovrFlag", int'(ovrFlag), 0);
    checkEq("R1 filtOut", int'(filtOut), 0);
    rstN = 1'b1;
    tick(2);

    // R2: three-edge pass-through
    zeroCounts();
    ownIn = 1'b1;
    tick(2); checkEq("R2 before third edge", int'(filtOut), 0);
    tick(1); checkEq("R2 after third edge", int'(filtOut), 1);
    tick(3); ownIn = 1'b0; tick(5);
    checkEq("R4 rise pulses", nRise, 1);
    checkEq("R4 fall pulses", nFall, 1);
    checkEq("R5 rising-only trig", nTrig, 1);

    polSel = 2'b01; zeroCounts();
    ownIn = 1'b1; tick(5); ownIn = 1'b0; tick(5);
    checkEq("R5 falling-only trig", nTrig, 1);
    polSel = 2'b10; zeroCounts();
    ownIn = 1'b1; tick(5); ownIn = 1'b0; tick(5);
    checkEq("R5 both-edge trig", nTrig, 2);

    // R3: filter length 2*k
    fltSel = 4'd3;
    ownIn = 1'b1; tick(4); ownIn = 1'b0; tick(10);
    checkEq("R3 short glitch ignored", int'(filtOut), 0);
    ownIn = 1'b1; tick(12);
    checkEq("R3 long high accepted", int'(filtOut), 1);
    ownIn = 1'b0; tick(12);
    checkEq("R3 long low accepted", int'(filtOut), 0);
    sampleTick = 1'b0; ownIn = 1'b1; tick(20);
    checkEq("R3 no tick no sample", int'(filtOut), 0);
    ownIn = 1'b0; sampleTick = 1'b1; tick(4);
    fltSel = '0; tick(4);

    // R6/R8: own source, falling active
    srcSel = 2'b01; polSel = 2'b01; capEn = 1'b1; divSel = '0;
    cntVal = 16'h1234; clearFlags();
    ownIn = 1'b1; tick(6);
    checkEq("R6 inactive edge no capture", int'(capFlag), 0);
    ownIn = 1'b0; tick(6);
    checkEq("R6 own falling capture", int'(capFlag), 1);
    checkEq("R8 captured count", int'(capVal), 16'h1234);

    // R6: adjacent source ignores own pin
    srcSel = 2'b10; polSel = 2'b00; cntVal = 16'h0BEE; clearFlags();
    ownIn = 1'b1; tick(6);
    checkEq("R6 own pin ignored", int'(capFlag), 0);
    nbrFilt = 1'b1; tick(2);
    checkEq("R6 adjacent capture", int'(capFlag), 1);
    checkEq("R6 adjacent value", int'(capVal), 16'h0BEE);
    nbrFilt = 1'b0; ownIn = 1'b0; tick(6);

    // R6: output mode
    srcSel = 2'b00; clearFlags();
    pulseTrig(16'h5555); nbrFilt = 1'b1; ownIn = 1'b1; tick(6);
    checkEq("R6 off mode flag", int'(capFlag), 0);
    checkEq("R6 off mode value", int'(capVal), 16'h0BEE);
    nbrFilt = 1'b0; ownIn = 1'b0; tick(6);

    // R8: disabled
    srcSel = 2'b11; capEn = 1'b0; tick(1);
    pulseTrig(16'h7777);
    checkEq("R8 disabled flag", int'(capFlag), 0);
    checkEq("R8 disabled value", int'(capVal), 16'h0BEE);

    // R9: overrun and clear
    capEn = 1'b1; clearFlags();
    pulseTrig(16'd1);
    checkEq("R9 first flag", int'(capFlag), 1);
    checkEq("R9 no overrun yet", int'(ovrFlag), 0);
    pulseTrig(16'd2);
    checkEq("R9 overrun set", int'(ovrFlag), 1);
    checkEq("R9 latest value", int'(capVal), 2);
    clearFlags();
    checkEq("R9 clear capFlag", int'(capFlag), 0);
    checkEq("R9 clear ovrFlag", int'(ovrFlag), 0);
    pulseTrig(16'd3);
    flagClr = 1'b1; trigIn = 1'b1; cntVal = 16'd4; tick(1);
    flagClr = 1'b0; trigIn = 1'b0;
    checkEq("R9 capture beats clear flag", int'(capFlag), 1);
    checkEq("R9 capture beats clear ovr", int'(ovrFlag), 0);

    // R10: prescaler restarts
    divSel = 2'd2; tick(1); restartPresc(); clearFlags();
    repeat (3) pulseTrig(16'd9);
    restartPresc();
    repeat (3) pulseTrig(16'd9);
    checkEq("R10 enable drop restarts", int'(capFlag), 0);
    pulseTrig(16'd10);
    checkEq("R10 fourth after restart", int'(capFlag), 1);
    restartPresc(); clearFlags();
    pulseTrig(16'd11);
    divSel = 2'd1; tick(1);
    pulseTrig(16'd12);
    checkEq("R10 ratio change restarts", int'(capFlag), 0);
    pulseTrig(16'd13);
    checkEq("R10 second after change", int'(capFlag), 1);

    // R7: random bursts
    for (int r = 0; r < 40; r++) begin
      int d, n, caps;
      logic [CW-1:0] lastV, v;
      d = int'($urandom % 4);
      n = int'($urandom % 20);
      caps = 0; lastV = '0;
      divSel = 2'(d); tick(1);
      restartPresc(); clearFlags();
      for (int i = 1; i <= n; i++) begin
        v = CW'($urandom);
        pulseTrig(v);
        tick(int'($urandom % 3));
        if (i % (1 << d) == 0) lastV = v;
      end
      caps = expCaps(n, d);
      checkEq("R7 flag", int'(capFlag), caps > 0 ? 1 : 0);
      checkEq("R7 overrun", int'(ovrFlag), caps > 1 ? 1 : 0);
      if (caps > 0) checkEq("R7 value", int'(capVal), int'(lastV));
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule